// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This controller erases one block of an 8-bit NAND flash device for a host. The host gives it a block number through a valid/ready request. The sequencer sends the erase setup opcode, two row-address bytes and the erase confirm opcode. It then issues the status opcode and keeps reading the status byte, with no further commands, until the device reports ready. It decodes the status byte into a two-bit result. Before it hands the result to the host, it writes the read-mode opcode, so that later page reads return array data instead of status bytes.

Every bus cycle is a single strobe: write-enable for command and address bytes, read-enable for status bytes. Each strobe is held low for `T_LO` system clocks and then high for at least `T_HI` clocks. Command-latch and address-latch mark each byte as a command or an address, and chip-enable stays asserted for the whole transaction. A clock-count limit stops a device that never becomes ready, and reports a timeout result in that case.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0, `nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0 and `nand_ale`=0.
- R2: An accepted request produces this sequence of write-strobe bytes:
  - 8'h60 with `nand_cle`=1;
  - two bytes with `nand_ale`=1;
  - 8'hD0 with `nand_cle`=1;
  - 8'h70 with `nand_cle`=1;
  - status reads;
  - 8'h00 with `nand_cle`=1.

  No other write-strobe bytes occur.
- R3: The row address places the block number at row bits 5 and up, with row bits 0–4 at zero. The first address byte is {block[2:0], 5'b00000}. The second address byte is {1'b0, block[9:3]}.
- R4: Every write or read strobe is low for exactly `T_LO` clocks. Between two strobes, both strobes stay high for at least `T_HI` clocks.
- R5: After 8'h70, read strobes repeat with no command in between, until a status byte with bit 6 = 1 is read. The read that shows ready is the last one.
- R6: Result codes are 0 = pass, 1 = fail, 2 = protected, 3 = timeout. A ready status with bit 7 = 0 gives 2, whatever bit 0 is. A ready status with bit 7 = 1 and bit 0 = 1 gives 1. Otherwise the result is 0.
- R7: If no ready status has been read by the first status read that completes `TIMEOUT_CYC` clocks or more after 8'h70 starts, the result is 3. The 8'h00 restore is still sent.
- R8: A request is accepted only while `req_ready`=1. A `req_valid` pulse during an operation has no effect: it starts no second sequence and does not change the address being sent.
- R9: `rsp_valid` and `rsp_code` stay stable until `rsp_ack`. One clock after the `rsp_ack`, `rsp_valid`=0 and `req_ready`=1.
- R10: `nand_cle` and `nand_ale` are never both high. The two strobes are never both low. `nand_dq_oe` is low whenever the read strobe is low.
- R11: `nand_ce_n` is low throughout every strobe of an operation. It is high while idle and while a result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| req_block | input | 10 | Block number to erase |
| rsp_valid | output | 1 | Result available |
| rsp_code | output | 2 | 0 pass, 1 fail, 2 protected, 3 timeout |
| rsp_ack | input | 1 | Host consumes the result |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Drive enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the device |

## Verification
The bench builds the sequencer with `T_LO`=2 and `T_HI`=3. Because the two widths differ, a swapped or off-by-one strobe count shows up in the measured widths. `TIMEOUT_CYC` is set to 200, so a device that never becomes ready reaches the timeout result after a few dozen status reads. A device model in the bench becomes ready after a chosen number of reads and returns chosen fail and protect bits. This covers the priority between protected and fail, single-read and multi-read polling, and the extreme block numbers.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    localparam int BLK_W      = 10;
    localparam int ROW_SKIP   = 5;
    localparam int ROW_W      = BLK_W + ROW_SKIP;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_READ_MODE   = 8'h00;

    localparam int ST_BIT_FAIL  = 0;
    localparam int ST_BIT_READY = 6;
    localparam int ST_BIT_WPN   = 7;

    typedef enum logic [1:0] {
        RES_PASS = 2'd0,
        RES_FAIL = 2'd1,
        RES_PROT = 2'd2,
        RES_TMO  = 2'd3
    } result_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_ADR_LO,
        SQ_ADR_HI,
        SQ_CONFIRM,
        SQ_STAT_CMD,
        SQ_POLL,
        SQ_RESTORE,
        SQ_REPORT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic    finished;
        result_e code;
    } poll_verdict_t;

    function automatic poll_verdict_t judge_status(input logic [7:0] stat, input logic expired);
        poll_verdict_t v;
        v.finished = 1'b0;
        v.code     = RES_PASS;
        if (stat[ST_BIT_READY]) begin
            v.finished = 1'b1;
            if (!stat[ST_BIT_WPN])
                v.code = RES_PROT;
            else if (stat[ST_BIT_FAIL])
                v.code = RES_FAIL;
            else
                v.code = RES_PASS;
        end else if (expired) begin
            v.finished = 1'b1;
            v.code     = RES_TMO;
        end
        return v;
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_erase_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd,
    input  logic       cle_in,
    input  logic       ale_in,
    input  logic [7:0] wdata,
    input  logic [7:0] dq_in,
    output logic       done,
    output logic [7:0] rdata,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_out,
    output logic       dq_oe
);

    localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [CW-1:0] LO_LAST = CW'(T_LO - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(T_HI - 1);

    typedef struct packed {
        phase_e      phase;
        logic [CW-1:0] cnt;
        logic        rd;
        logic        cle;
        logic        ale;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
    } cyc_t;

    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        done  = 1'b0;
        case (cyc_q.phase)
            PH_IDLE: begin
                if (start) begin
                    cyc_d.phase = PH_LOW;
                    cyc_d.cnt   = '0;
                    cyc_d.rd    = rd;
                    cyc_d.cle   = cle_in;
                    cyc_d.ale   = ale_in;
                    cyc_d.wdata = wdata;
                end
            end
            PH_LOW: begin
                if (cyc_q.cnt == LO_LAST) begin
                    cyc_d.phase = PH_HIGH;
                    cyc_d.cnt   = '0;
                    if (cyc_q.rd)
                        cyc_d.rdata = dq_in;
                end else begin
                    cyc_d.cnt = cyc_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (cyc_q.cnt == HI_LAST) begin
                    done        = 1'b1;
                    cyc_d.phase = PH_IDLE;
                    cyc_d.cnt   = '0;
                    cyc_d.cle   = 1'b0;
                    cyc_d.ale   = 1'b0;
                end else begin
                    cyc_d.cnt = cyc_q.cnt + 1'b1;
                end
            end
            default: cyc_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc_q <= '{phase: PH_IDLE, default: '0};
        else
            cyc_q <= cyc_d;
    end

    assign we_n   = !(cyc_q.phase == PH_LOW && !cyc_q.rd);
    assign re_n   = !(cyc_q.phase == PH_LOW && cyc_q.rd);
    assign cle    = cyc_q.cle;
    assign ale    = cyc_q.ale;
    assign dq_out = cyc_q.wdata;
    assign dq_oe  = (cyc_q.phase != PH_IDLE) && !cyc_q.rd;
    assign rdata  = cyc_q.rdata;

    // R4: a strobe that has not reached its last low clock stays low
    a_r4_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && cyc_q.cnt != LO_LAST) |=> !we_n);
    a_r4_read_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n && cyc_q.cnt != LO_LAST) |=> !re_n);
    // R4: the counter never leaves the range of the longer phase
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cyc_q.cnt) < TMAX);

endmodule

// File: rtl/nand_poll_timer.sv
module nand_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] CAP = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && cnt_q != CAP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CAP);

    // R7: once reached, the limit stays reached until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);
    // R7: counting advances by exactly one per running clock
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !expired) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int T_LO        = 2,
    parameter int T_HI        = 2,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_block,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    input  logic             rsp_ack,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in
);

    typedef struct packed {
        seq_state_e        state;
        logic              issued;
        logic [BLK_W-1:0]  block;
        result_e           code;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          use_bus, bus_start, bus_rd, bus_cle, bus_ale, bus_done;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          tmr_clr, tmr_run, tmr_expired;
    logic [ROW_W-1:0] row_addr;
    poll_verdict_t verdict;

    assign row_addr = {seq_q.block, {ROW_SKIP{1'b0}}};
    assign verdict  = judge_status(bus_rdata, tmr_expired);

    always_comb begin
        seq_d     = seq_q;
        use_bus   = 1'b0;
        bus_rd    = 1'b0;
        bus_cle   = 1'b0;
        bus_ale   = 1'b0;
        bus_wdata = '0;
        tmr_clr   = 1'b0;
        tmr_run   = 1'b0;

        case (seq_q.state)
            SQ_IDLE: begin
                tmr_clr = 1'b1;
                if (req_valid) begin
                    seq_d.block  = req_block;
                    seq_d.issued = 1'b0;
                    seq_d.state  = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                use_bus   = 1'b1;
                bus_cle   = 1'b1;
                bus_wdata = OP_ERASE_SETUP;
            end
            SQ_ADR_LO: begin
                use_bus   = 1'b1;
                bus_ale   = 1'b1;
                bus_wdata = row_addr[7:0];
            end
            SQ_ADR_HI: begin
                use_bus   = 1'b1;
                bus_ale   = 1'b1;
                bus_wdata = 8'(row_addr[ROW_W-1:8]);
            end
            SQ_CONFIRM: begin
                use_bus   = 1'b1;
                bus_cle   = 1'b1;
                bus_wdata = OP_ERASE_GO;
            end
            SQ_STAT_CMD: begin
                use_bus   = 1'b1;
                bus_cle   = 1'b1;
                bus_wdata = OP_STATUS;
                tmr_run   = 1'b1;
            end
            SQ_POLL: begin
                use_bus = 1'b1;
                bus_rd  = 1'b1;
                tmr_run = 1'b1;
            end
            SQ_RESTORE: begin
                use_bus   = 1'b1;
                bus_cle   = 1'b1;
                bus_wdata = OP_READ_MODE;
            end
            SQ_REPORT: begin
                if (rsp_ack)
                    seq_d.state = SQ_IDLE;
            end
            default: seq_d.state = SQ_IDLE;
        endcase

        bus_start = use_bus && !seq_q.issued;
        if (bus_start)
            seq_d.issued = 1'b1;

        if (use_bus && bus_done) begin
            seq_d.issued = 1'b0;
            case (seq_q.state)
                SQ_SETUP:    seq_d.state = SQ_ADR_LO;
                SQ_ADR_LO:   seq_d.state = SQ_ADR_HI;
                SQ_ADR_HI:   seq_d.state = SQ_CONFIRM;
                SQ_CONFIRM:  seq_d.state = SQ_STAT_CMD;
                SQ_STAT_CMD: seq_d.state = SQ_POLL;
                SQ_POLL: begin
                    if (verdict.finished) begin
                        seq_d.code  = verdict.code;
                        seq_d.state = SQ_RESTORE;
                    end
                end
                SQ_RESTORE:  seq_d.state = SQ_REPORT;
                default:     seq_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '{state: SQ_IDLE, code: RES_PASS, default: '0};
        else
            seq_q <= seq_d;
    end

    nand_bus_cycle #(
        .T_LO (T_LO),
        .T_HI (T_HI)
    ) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bus_start),
        .rd     (bus_rd),
        .cle_in (bus_cle),
        .ale_in (bus_ale),
        .wdata  (bus_wdata),
        .dq_in  (nand_dq_in),
        .done   (bus_done),
        .rdata  (bus_rdata),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe)
    );

    nand_poll_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    assign req_ready = (seq_q.state == SQ_IDLE);
    assign rsp_valid = (seq_q.state == SQ_REPORT);
    assign rsp_code  = seq_q.code;
    assign nand_ce_n = (seq_q.state == SQ_IDLE) || (seq_q.state == SQ_REPORT);

    // R10: latch enables exclusive, strobes exclusive, no drive while reading
    a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);
    // R9: a pending result is held until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_code)));
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |=> (!rsp_valid && req_ready));
    // R8: no acceptance while a result waits
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R11: chip enable covers every strobe
    a_r11_ce_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

endmodule

// File: tb/tb_nand_erase_seq.sv
module tb_nand_erase_seq;
    import nand_erase_pkg::*;

    localparam int T_LO = 2;
    localparam int T_HI = 3;
    localparam int TMO  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BLK_W-1:0] req_block = '0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic rsp_ack = 1'b0;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out, nand_dq_in;

    always #5 clk = ~clk;

    nand_erase_seq #(.T_LO(T_LO), .T_HI(T_HI), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_ack(rsp_ack),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    int errors = 0;
    int checks = 0;

    // device model
    int  m_busy_reads = 0;
    bit  m_never = 1'b0;
    bit  m_fail = 1'b0;
    bit  m_prot = 1'b0;
    int  reads_done = 0;
    bit  m_ready;
    assign m_ready = !m_never && (reads_done >= m_busy_reads);
    assign nand_dq_in = {~m_prot, m_ready, 5'b00000, m_fail};

    // bus monitor
    logic [9:0] wlog [0:63];
    int  log_n = 0;
    int  we_lo = 0, re_lo = 0, gap = 0;
    bit  seen_pulse = 1'b0;
    int  width_err = 0, rule_err = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [9:0] cap;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) begin
                we_lo++;
                cap = {nand_cle, nand_ale, nand_dq_out};
            end
            if (!nand_re_n) re_lo++;
            if ((prev_we && !nand_we_n) || (prev_re && !nand_re_n)) begin
                if (seen_pulse && gap < T_HI) width_err++;
            end
            if (!prev_we && nand_we_n) begin
                if (log_n < 64) wlog[log_n] = cap;
                log_n++;
                if (we_lo != T_LO) width_err++;
                we_lo = 0; gap = 0; seen_pulse = 1'b1;
            end
            if (!prev_re && nand_re_n) begin
                reads_done++;
                if (re_lo != T_LO) width_err++;
                re_lo = 0; gap = 0; seen_pulse = 1'b1;
            end
            if (nand_we_n && nand_re_n) gap++;
            if (nand_cle && nand_ale) rule_err++;
            if (!nand_we_n && !nand_re_n) rule_err++;
            if (!nand_re_n && nand_dq_oe) rule_err++;
            if ((!nand_we_n || !nand_re_n) && nand_ce_n) rule_err++;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_monitor();
        log_n = 0; reads_done = 0; width_err = 0; rule_err = 0;
        seen_pulse = 1'b0; gap = 0; we_lo = 0; re_lo = 0;
    endtask

    task automatic launch(input logic [BLK_W-1:0] blk);
        @(negedge clk);
        req_block = blk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result();
        for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    endtask

    task automatic ack_and_check(input string tag);
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(!rsp_valid && req_ready, tag, {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic check_frame(input logic [BLK_W-1:0] blk);
        logic [ROW_W-1:0] row;
        row = {blk, 5'b00000};
        chk(log_n == 6, "R2 write byte count", log_n, 6);
        chk(wlog[0] == {2'b10, 8'h60}, "R2 setup opcode", wlog[0], {2'b10, 8'h60});
        chk(wlog[1] == {2'b01, row[7:0]}, "R3 first address byte", wlog[1], {2'b01, row[7:0]});
        chk(wlog[2] == {2'b01, 1'b0, row[14:8]}, "R3 second address byte", wlog[2], {2'b01, 1'b0, row[14:8]});
        chk(wlog[3] == {2'b10, 8'hD0}, "R2 confirm opcode", wlog[3], {2'b10, 8'hD0});
        chk(wlog[4] == {2'b10, 8'h70}, "R2 status opcode", wlog[4], {2'b10, 8'h70});
        chk(wlog[5] == {2'b10, 8'h00}, "R2 restore opcode", wlog[5], {2'b10, 8'h00});
        chk(width_err == 0, "R4 strobe widths", width_err, 0);
        chk(rule_err == 0, "R10 R11 bus rules", rule_err, 0);
        chk(nand_ce_n == 1'b1, "R11 ce released while result waits", nand_ce_n, 1);
    endtask

    task automatic t_reset();
        chk(req_ready && !rsp_valid, "R1 handshake reset", {req_ready, rsp_valid}, 2'b10);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R1 bus idle", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    endtask

    task automatic t_pass();
        clear_monitor();
        m_busy_reads = 3; m_never = 0; m_fail = 0; m_prot = 0;
        launch(10'h2A5);
        wait_result();
        chk(rsp_valid && rsp_code == 2'd0, "R6 pass result", rsp_code, 0);
        chk(reads_done == 4, "R5 polls until ready", reads_done, 4);
        check_frame(10'h2A5);
        ack_and_check("R9 release after ack");
    endtask

    task automatic t_fail();
        clear_monitor();
        m_busy_reads = 0; m_never = 0; m_fail = 1; m_prot = 0;
        launch(10'h3FF);
        wait_result();
        chk(rsp_code == 2'd1, "R6 fail result", rsp_code, 1);
        chk(reads_done == 1, "R5 single read when ready at once", reads_done, 1);
        check_frame(10'h3FF);
        ack_and_check("R9 release after fail");
    endtask

    task automatic t_prot();
        clear_monitor();
        m_busy_reads = 2; m_never = 0; m_fail = 1; m_prot = 1;
        launch(10'h000);
        wait_result();
        chk(rsp_code == 2'd2, "R6 protect has priority", rsp_code, 2);
        check_frame(10'h000);
        ack_and_check("R9 release after protect");
        m_prot = 0; m_fail = 0;
    endtask

    task automatic t_timeout();
        clear_monitor();
        m_never = 1; m_fail = 0; m_prot = 0;
        launch(10'h155);
        wait_result();
        chk(rsp_code == 2'd3, "R7 timeout result", rsp_code, 3);
        chk(reads_done > 20, "R7 R5 many polls before timeout", reads_done, 21);
        check_frame(10'h155);
        ack_and_check("R9 release after timeout");
        m_never = 0;
    endtask

    task automatic t_busy_and_hold();
        clear_monitor();
        m_busy_reads = 5; m_fail = 0; m_prot = 0;
        launch(10'h0F3);
        repeat (3) @(negedge clk);
        chk(!req_ready, "R8 not ready while busy", req_ready, 0);
        req_block = 10'h30C;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        check_frame(10'h0F3);
        chk(rsp_code == 2'd0, "R8 first request completes", rsp_code, 0);
        repeat (10) @(negedge clk);
        chk(rsp_valid && rsp_code == 2'd0, "R9 result held without ack", {rsp_valid, rsp_code}, 3'b100);
        chk(!req_ready, "R8 not ready while result waits", req_ready, 0);
        ack_and_check("R9 release after hold");
        repeat (20) @(negedge clk);
        chk(log_n == 6, "R8 ignored request starts nothing", log_n, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_pass();
        t_fail();
        t_prot();
        t_timeout();
        t_busy_and_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule